// File: doc/BRIEF.md
# I/O Window Address Translator

This block bridges single-beat I/O accesses from an internal system bus to a PCI-style local bus. A request whose address lies in a fixed 2 MB window is claimed. Requests that ask for a burst, are larger than one 32-bit word, or are misaligned are refused. The block returns an error response for a refused request and never forwards it.

An accepted request is given a new 32-bit address built from three parts. The low bits are copied from the request. The upper bits always come from a programmable base register. Each of the three middle bits is taken either from the request or from the base, one bit at a time, as a mask register selects. The access size and the low address bits become four byte enables. A control bit can reverse the four byte lanes of the enables, the write data and the returned read data. This bridges a big-endian internal bus to a little-endian external one.

The base, mask and control settings are written through a separate register port that supports byte enables. The request side uses a valid/ready handshake. The downstream side holds a forwarded transfer until ready is given.

Top module: `ioWinXlate`

## Requirements
- R1: `reqReady` is high only when the block is idle and `reqAddr[31:21]` equals 0x7E9, which is the window 0xFD20_0000 to 0xFD3F_FFFF. A request outside the window is never accepted and gets no response.
- R2: An accepted request with `reqBurst` high is never forwarded. In the cycle after acceptance, `rspValid` and `rspErr` are both high and `rspRdata` is zero.
- R3: `reqSize` is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Size 3 is always refused. Size 1 with `reqAddr[0]` set is refused. Size 2 with `reqAddr[1:0]` nonzero is refused. All refusals give the error response of R2.
- R4: `dnAddr[17:0]` equals `reqAddr[17:0]` of the accepted request.
- R5: For each n in 18..20, `dnAddr[n]` is `reqAddr[n]` when mask bit n is 1, and base bit n when mask bit n is 0. Each bit is chosen on its own.
- R6: `dnAddr[31:21]` equals base register bits [31:21], whatever the request's upper bits are.
- R7: Byte enable bit i covers data bits [8i+7:8i]. Before any swap, the enables are 1 << a, 3 << a, or 0xF for sizes 0, 1 and 2, where a = `reqAddr[1:0]`.
- R8: When control bit 0 is 1 at acceptance, byte lane i of `dnBe`, `dnWdata` and the returned `rspRdata` comes from lane 3-i. When it is 0, lanes pass straight through.
- R9: On the register port, `regSel` 0 selects the base register (only bits [31:18] are kept), 1 selects the mask (only bits [20:18] are kept), and 2 selects the control register (only bit 0 is kept). `regSel` 3 writes nothing and reads zero. `regBe[i]` enables writing byte i. `regRdata` shows the selected register. All registers reset to zero.
- R10: `dnValid`, `dnAddr`, `dnBe`, `dnWrite` and `dnWdata` stay stable until `dnReady`. In the cycle after the `dnValid`/`dnReady` handshake, `rspValid` is high, `rspErr` is low, and `rspRdata` holds the `dnRdata` sampled at the handshake (lane-swapped if R8 applies).
- R11: While a forwarded transfer is outstanding, `reqReady` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base, 1 mask, 2 control |
| regBe | input | 4 | Byte enables for the register write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Contents of the selected register |
| reqValid | input | 1 | Upstream request valid |
| reqReady | output | 1 | Upstream request accepted |
| reqAddr | input | 32 | Upstream byte address |
| reqSize | input | 2 | Access size code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | Burst requested |
| reqWdata | input | 32 | Upstream write data |
| rspValid | output | 1 | One-cycle response pulse |
| rspErr | output | 1 | Response is a refusal |
| rspRdata | output | 32 | Read data returned upstream |
| dnValid | output | 1 | Downstream transfer valid |
| dnReady | input | 1 | Downstream accepts the transfer |
| dnAddr | output | 32 | Translated address |
| dnBe | output | 4 | Downstream byte enables |
| dnWrite | output | 1 | Downstream direction |
| dnWdata | output | 32 | Downstream write data |
| dnRdata | input | 32 | Downstream read data, sampled at the handshake |

## Verification
A stale or wrong base or mask register shows up in `dnAddr` in the first cycle of the next forwarded transfer. Register readback also shows it at once on `regRdata`. A state machine stuck busy holds `reqReady` low. A state machine that drops busy too early causes `dnValid` to fall without `dnReady`, or lets a second request be accepted. Either is visible in the same cycle. A swap bit latched at the wrong time reverses lanes in `dnBe` or `rspRdata` on that very transfer. Comparing every output against a model on every clock therefore catches each of these faults within one cycle.

// File: rtl/ioWinPkg.sv
package ioWinPkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDn;     // latch a good request toward downstream
    logic captureRsp; // downstream handshake: capture read data
    logic errRsp;     // refused request: clear read data
  } ctlStrobe_t;

endpackage

// File: rtl/ioWinRegs.sv
module ioWinRegs #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int HI_LSB  = 21,
  parameter int MID_LSB = 18
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWe,
  input  logic [1:0]                regSel,
  input  logic [DATA_W/8-1:0]       regBe,
  input  logic [DATA_W-1:0]         regWdata,
  output logic [DATA_W-1:0]         regRdata,
  output logic [ADDR_W-HI_LSB-1:0]  baseHi,
  output logic [HI_LSB-MID_LSB-1:0] baseMid,
  output logic [HI_LSB-MID_LSB-1:0] maskMid,
  output logic                      swapEn
);
  import ioWinPkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int HI_W  = ADDR_W - HI_LSB;
  localparam int MID_W = HI_LSB - MID_LSB;

  logic [HI_W-1:0]  baseHiQ;
  logic [MID_W-1:0] baseMidQ;
  logic [MID_W-1:0] maskQ;
  logic             swapQ;

  logic [DATA_W-1:0] baseImg, maskImg, ctrlImg;
  logic [DATA_W-1:0] baseNew, maskNew, ctrlNew;

  assign baseImg = {baseHiQ, baseMidQ, {MID_LSB{1'b0}}};
  assign maskImg = {{HI_W{1'b0}}, maskQ, {MID_LSB{1'b0}}};
  assign ctrlImg = {{(DATA_W-1){1'b0}}, swapQ};

  // byte-lane merge of new data over current images
  for (genvar i = 0; i < LANES; i++) begin : gMerge
    assign baseNew[8*i +: 8] = regBe[i] ? regWdata[8*i +: 8] : baseImg[8*i +: 8];
    assign maskNew[8*i +: 8] = regBe[i] ? regWdata[8*i +: 8] : maskImg[8*i +: 8];
    assign ctrlNew[8*i +: 8] = regBe[i] ? regWdata[8*i +: 8] : ctrlImg[8*i +: 8];
  end

  // bits that have no storage behind them
  logic unusedBits;
  assign unusedBits = ^{baseNew[MID_LSB-1:0], maskNew[ADDR_W-1:HI_LSB],
                        maskNew[MID_LSB-1:0], ctrlNew[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHiQ  <= '0;
      baseMidQ <= '0;
      maskQ    <= '0;
      swapQ    <= 1'b0;
    end else if (regWe) begin
      case (regSel_e'(regSel))
        SEL_BASE: begin
          baseHiQ  <= baseNew[ADDR_W-1:HI_LSB];
          baseMidQ <= baseNew[HI_LSB-1:MID_LSB];
        end
        SEL_MASK: maskQ <= maskNew[HI_LSB-1:MID_LSB];
        SEL_CTRL: swapQ <= ctrlNew[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regSel_e'(regSel))
      SEL_BASE: regRdata = baseImg;
      SEL_MASK: regRdata = maskImg;
      SEL_CTRL: regRdata = ctrlImg;
      default:  regRdata = '0;
    endcase
  end

  assign baseHi  = baseHiQ;
  assign baseMid = baseMidQ;
  assign maskMid = maskQ;
  assign swapEn  = swapQ;

endmodule

// File: rtl/ioWinCtrl.sv
module ioWinCtrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqHit,
  input  logic                  reqBad,
  input  logic                  dnReady,
  output logic                  reqReady,
  output logic                  dnValid,
  output logic                  rspValid,
  output logic                  rspErr,
  output ioWinPkg::ctlStrobe_t  strobe
);
  import ioWinPkg::*;

  ctlState_e state, stateNext;
  logic      accept;
  logic      rspValidQ, rspErrQ;

  assign reqReady = (state == ST_IDLE) && reqHit;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe.loadDn     = accept && !reqBad;
    strobe.errRsp     = accept && reqBad;
    strobe.captureRsp = (state == ST_BUSY) && dnReady;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.loadDn)     stateNext = ST_BUSY;
      ST_BUSY: if (strobe.captureRsp) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rspValidQ <= 1'b0;
      rspErrQ   <= 1'b0;
    end else begin
      state     <= stateNext;
      rspValidQ <= strobe.errRsp || strobe.captureRsp;
      rspErrQ   <= strobe.errRsp;
    end
  end

  assign dnValid  = (state == ST_BUSY);
  assign rspValid = rspValidQ;
  assign rspErr   = rspErrQ;

endmodule

// File: rtl/ioWinDatapath.sv
module ioWinDatapath #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          HI_LSB   = 21,
  parameter int          MID_LSB  = 18,
  parameter logic [31:0] WIN_BASE = 32'hFD20_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ioWinPkg::ctlStrobe_t      strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqSize,
  input  logic                      reqWrite,
  input  logic                      reqBurst,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [ADDR_W-HI_LSB-1:0]  baseHi,
  input  logic [HI_LSB-MID_LSB-1:0] baseMid,
  input  logic [HI_LSB-MID_LSB-1:0] maskMid,
  input  logic                      swapEn,
  input  logic [DATA_W-1:0]         dnRdata,
  output logic                      reqHit,
  output logic                      reqBad,
  output logic [ADDR_W-1:0]         dnAddr,
  output logic [DATA_W/8-1:0]       dnBe,
  output logic                      dnWrite,
  output logic [DATA_W-1:0]         dnWdata,
  output logic [DATA_W-1:0]         rspRdata
);
  import ioWinPkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int MID_W = HI_LSB - MID_LSB;
  localparam logic [ADDR_W-HI_LSB-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:HI_LSB];

  // window decode
  assign reqHit = (reqAddr[ADDR_W-1:HI_LSB] == WIN_TAG);

  // size / alignment check
  logic sizeBad;
  always_comb begin
    case (accSize_e'(reqSize))
      SZ_BYTE: sizeBad = 1'b0;
      SZ_HALF: sizeBad = reqAddr[0];
      SZ_WORD: sizeBad = |reqAddr[OFF_W-1:0];
      default: sizeBad = 1'b1;
    endcase
  end
  assign reqBad = reqBurst || sizeBad;

  // byte enables from size and offset
  logic [LANES-1:0] beRaw, beShift, beSw;
  always_comb begin
    case (accSize_e'(reqSize))
      SZ_BYTE: beRaw = LANES'(1);
      SZ_HALF: beRaw = LANES'(3);
      SZ_WORD: beRaw = '1;
      default: beRaw = '0;
    endcase
  end
  assign beShift = beRaw << reqAddr[OFF_W-1:0];

  // three-part address splice; middle bits chosen one by one
  logic [MID_W-1:0]  midSel;
  logic [ADDR_W-1:0] spliceAddr;
  for (genvar m = 0; m < MID_W; m++) begin : gMid
    assign midSel[m] = maskMid[m] ? reqAddr[MID_LSB+m] : baseMid[m];
  end
  assign spliceAddr = {baseHi, midSel, reqAddr[MID_LSB-1:0]};

  // lane reversal for endian conversion
  logic             swapLatQ;
  logic [DATA_W-1:0] wdSw, rdSw;
  for (genvar i = 0; i < LANES; i++) begin : gSwap
    assign beSw[i]        = swapEn   ? beShift[LANES-1-i]            : beShift[i];
    assign wdSw[8*i +: 8] = swapEn   ? reqWdata[8*(LANES-1-i) +: 8]  : reqWdata[8*i +: 8];
    assign rdSw[8*i +: 8] = swapLatQ ? dnRdata[8*(LANES-1-i) +: 8]   : dnRdata[8*i +: 8];
  end

  logic [ADDR_W-1:0] dnAddrQ;
  logic [LANES-1:0]  dnBeQ;
  logic              dnWriteQ;
  logic [DATA_W-1:0] dnWdataQ, rspRdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dnAddrQ   <= '0;
      dnBeQ     <= '0;
      dnWriteQ  <= 1'b0;
      dnWdataQ  <= '0;
      swapLatQ  <= 1'b0;
      rspRdataQ <= '0;
    end else begin
      if (strobe.loadDn) begin
        dnAddrQ  <= spliceAddr;
        dnBeQ    <= beSw;
        dnWriteQ <= reqWrite;
        dnWdataQ <= wdSw;
        swapLatQ <= swapEn;
      end
      if (strobe.captureRsp)  rspRdataQ <= rdSw;
      else if (strobe.errRsp) rspRdataQ <= '0;
    end
  end

  assign dnAddr   = dnAddrQ;
  assign dnBe     = dnBeQ;
  assign dnWrite  = dnWriteQ;
  assign dnWdata  = dnWdataQ;
  assign rspRdata = rspRdataQ;

endmodule

// File: rtl/ioWinXlate.sv
module ioWinXlate #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          HI_LSB   = 21,
  parameter int          MID_LSB  = 18,
  parameter logic [31:0] WIN_BASE = 32'hFD20_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regSel,
  input  logic [DATA_W/8-1:0] regBe,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic                reqWrite,
  input  logic                reqBurst,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                dnValid,
  input  logic                dnReady,
  output logic [ADDR_W-1:0]   dnAddr,
  output logic [DATA_W/8-1:0] dnBe,
  output logic                dnWrite,
  output logic [DATA_W-1:0]   dnWdata,
  input  logic [DATA_W-1:0]   dnRdata
);
  import ioWinPkg::*;

  localparam int HI_W  = ADDR_W - HI_LSB;
  localparam int MID_W = HI_LSB - MID_LSB;

  logic [HI_W-1:0]  baseHi;
  logic [MID_W-1:0] baseMid, maskMid;
  logic             swapEn, reqHit, reqBad;
  ctlStrobe_t       strobe;

  ioWinRegs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_LSB(HI_LSB), .MID_LSB(MID_LSB)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regBe(regBe),
    .regWdata(regWdata), .regRdata(regRdata), .baseHi(baseHi),
    .baseMid(baseMid), .maskMid(maskMid), .swapEn(swapEn)
  );

  ioWinCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHit(reqHit),
    .reqBad(reqBad), .dnReady(dnReady), .reqReady(reqReady),
    .dnValid(dnValid), .rspValid(rspValid), .rspErr(rspErr), .strobe(strobe)
  );

  ioWinDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_LSB(HI_LSB), .MID_LSB(MID_LSB),
    .WIN_BASE(WIN_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqBurst(reqBurst),
    .reqWdata(reqWdata), .baseHi(baseHi), .baseMid(baseMid),
    .maskMid(maskMid), .swapEn(swapEn), .dnRdata(dnRdata),
    .reqHit(reqHit), .reqBad(reqBad), .dnAddr(dnAddr), .dnBe(dnBe),
    .dnWrite(dnWrite), .dnWdata(dnWdata), .rspRdata(rspRdata)
  );

endmodule

// File: rtl/ioWinChk.sv
module ioWinChk #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          HI_LSB   = 21,
  parameter logic [31:0] WIN_BASE = 32'hFD20_0000
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [1:0]          reqSize,
  input logic                reqBurst,
  input logic                rspValid,
  input logic                rspErr,
  input logic                dnValid,
  input logic                dnReady,
  input logic [ADDR_W-1:0]   dnAddr,
  input logic [DATA_W/8-1:0] dnBe,
  input logic [DATA_W-1:0]   dnWdata
);
  localparam logic [ADDR_W-HI_LSB-1:0] TAG = WIN_BASE[ADDR_W-1:HI_LSB];

  a_r1_claim_window: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (reqAddr[ADDR_W-1:HI_LSB] == TAG));

  a_r2_burst_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqBurst) |=> (rspValid && rspErr && !dnValid));

  a_r3_oversize_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqSize == 2'd3) |=> (rspValid && rspErr));

  a_r7_be_count: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> ($countones(dnBe) == 1 || $countones(dnBe) == 2 || $countones(dnBe) == 4));

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnReady) |=> (dnValid && $stable(dnAddr) && $stable(dnBe) && $stable(dnWdata)));

  a_r10_good_response: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && dnReady) |=> (rspValid && !rspErr && !dnValid));

  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> !reqReady);

endmodule

bind ioWinXlate ioWinChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_LSB(HI_LSB), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqSize(reqSize), .reqBurst(reqBurst),
  .rspValid(rspValid), .rspErr(rspErr), .dnValid(dnValid),
  .dnReady(dnReady), .dnAddr(dnAddr), .dnBe(dnBe), .dnWdata(dnWdata)
);

// File: tb/ioWinXlate_tb.sv
module ioWinXlate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [3:0]  regBe = 4'h0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqWrite = 1'b0;
  logic        reqBurst = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspErr;
  logic [31:0] rspRdata;
  logic        dnValid;
  logic        dnReady = 1'b0;
  logic [31:0] dnAddr;
  logic [3:0]  dnBe;
  logic        dnWrite;
  logic [31:0] dnWdata;
  logic [31:0] dnRdata = '0;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ioWinXlate u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regBe(regBe),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .dnValid(dnValid), .dnReady(dnReady), .dnAddr(dnAddr), .dnBe(dnBe),
    .dnWrite(dnWrite), .dnWdata(dnWdata), .dnRdata(dnRdata)
  );

  // ---------------- reference model ----------------
  logic [31:0] mBase, mMask;
  bit          mSwap, mSwapLat, mBusy, mRspV, mRspErr, mWrite, mAccepted;
  logic [31:0] mAddr, mWdata, mRdata;
  logic [3:0]  mBe;

  function automatic logic [31:0] revBytes(logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = v[8*(3-k) +: 8];
    return r;
  endfunction

  function automatic logic [3:0] revLanes(logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  function automatic bit inWin(logic [31:0] a);
    return (a >= 32'hFD20_0000) && (a <= 32'hFD3F_FFFF);
  endfunction

  function automatic bit refused(logic [31:0] a, logic [1:0] sz, bit burst);
    int bytes = 1 << sz;
    return burst || bytes > 4 || (a % bytes) != 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBase = 0; mMask = 0; mSwap = 0; mSwapLat = 0; mBusy = 0;
      mRspV = 0; mRspErr = 0; mRdata = 0; mAddr = 0; mBe = 0;
      mWdata = 0; mWrite = 0; mAccepted = 0;
    end else begin
      mAccepted = reqValid && !mBusy && inWin(reqAddr);
      mRspV = 0; mRspErr = 0;
      if (mBusy && dnReady) begin
        mBusy = 0; mRspV = 1;
        mRdata = mSwapLat ? revBytes(dnRdata) : dnRdata;
      end else if (mAccepted) begin
        if (refused(reqAddr, reqSize, reqBurst)) begin
          mRspV = 1; mRspErr = 1; mRdata = 0;
        end else begin
          mBusy = 1;
          for (int b = 0; b < 32; b++) begin
            if (b >= 21)      mAddr[b] = mBase[b];
            else if (b >= 18) mAddr[b] = mMask[b] ? reqAddr[b] : mBase[b];
            else              mAddr[b] = reqAddr[b];
          end
          mBe = 4'(((1 << (1 << reqSize)) - 1) << (reqAddr % 4));
          mWdata = reqWdata;
          if (mSwap) begin mBe = revLanes(mBe); mWdata = revBytes(mWdata); end
          mWrite = reqWrite;
          mSwapLat = mSwap;
        end
      end
      if (regWe) begin
        for (int k = 0; k < 4; k++) if (regBe[k]) begin
          if (regSel == 0) mBase[8*k +: 8] = regWdata[8*k +: 8];
          if (regSel == 1) mMask[8*k +: 8] = regWdata[8*k +: 8];
          if (regSel == 2 && k == 0) mSwap = regWdata[0];
        end
        mBase = mBase & 32'hFFFC_0000;
        mMask = mMask & 32'h001C_0000;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [31:0] expReg;
    case (regSel)
      2'd0: expReg = mBase;
      2'd1: expReg = mMask;
      2'd2: expReg = {31'b0, mSwap};
      default: expReg = 0;
    endcase
    chk("R9 regRdata", regRdata, expReg);
    chk("R1/R11 reqReady", {31'b0, reqReady}, {31'b0, rstN && !mBusy && inWin(reqAddr)});
    chk("R10 dnValid", {31'b0, dnValid}, {31'b0, mBusy});
    chk("R2/R10 rspValid", {31'b0, rspValid}, {31'b0, mRspV});
    if (mBusy) begin
      chk("R4/R5/R6 dnAddr", dnAddr, mAddr);
      chk("R7/R8 dnBe", {28'b0, dnBe}, {28'b0, mBe});
      chk("R8 dnWdata", dnWdata, mWdata);
      chk("R10 dnWrite", {31'b0, dnWrite}, {31'b0, mWrite});
    end
    if (mRspV) begin
      chk("R2/R3 rspErr", {31'b0, rspErr}, {31'b0, mRspErr});
      chk("R8/R10 rspRdata", rspRdata, mRdata);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cycles++;
    dnReady = ($urandom_range(0, 2) == 0);
    dnRdata = $urandom;
    #1 checkAll();
  endtask

  task automatic regWr(logic [1:0] sel, logic [3:0] be, logic [31:0] d);
    regWe = 1; regSel = sel; regBe = be; regWdata = d;
    cycle();
    regWe = 0;
    cycle();
  endtask

  task automatic issue(logic [31:0] a, logic [1:0] sz, bit wr, bit burst, logic [31:0] wd);
    reqValid = 1; reqAddr = a; reqSize = sz; reqWrite = wr; reqBurst = burst; reqWdata = wd;
    for (int n = 0; n < 4; n++) begin
      cycle();
      if (mAccepted) break;
    end
    reqValid = 0;
    for (int n = 0; n < 60 && (mBusy || mRspV); n++) cycle();
    cycle();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > 100000) begin
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) cycle();
    rstN = 1;
    cycle();
    // R9 reset values of every register
    for (int s = 0; s < 4; s++) begin regSel = 2'(s); cycle(); end

    // R9 full and partial writes, unused select
    regWr(2'd0, 4'hF, 32'hABCD_E123);
    regWr(2'd1, 4'hF, 32'hFFFF_FFFF);
    regWr(2'd1, 4'hB, 32'h0000_0000);
    regWr(2'd3, 4'hF, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin regSel = 2'(s); cycle(); end
    regWr(2'd0, 4'h4, 32'h0055_0000);
    regSel = 2'd0; cycle();

    // R4 R5 R6 R7 mask all pass-through, sizes and offsets
    issue(32'hFD3F_FFFF, 2'd0, 0, 0, 0);
    issue(32'hFD2A_BCD6, 2'd1, 1, 0, 32'h1122_3344);
    issue(32'hFD35_5558, 2'd2, 1, 0, 32'hDEAD_BEEF);
    issue(32'hFD20_0001, 2'd0, 0, 0, 0);
    // R5 mixed mask patterns
    regWr(2'd1, 4'hF, 32'h0014_0000); // 101
    issue(32'hFD3C_0004, 2'd2, 0, 0, 0);
    regWr(2'd1, 4'hF, 32'h0008_0000); // 010
    issue(32'hFD2C_0002, 2'd1, 0, 0, 0);
    regWr(2'd1, 4'hF, 32'h0);         // 000
    issue(32'hFD3C_1000, 2'd2, 1, 0, 32'h0BAD_F00D);

    // R8 swap on
    regWr(2'd2, 4'h1, 32'h1);
    issue(32'hFD20_0010, 2'd2, 1, 0, 32'h0102_0304);
    issue(32'hFD20_0011, 2'd0, 0, 0, 0);
    issue(32'hFD20_0012, 2'd1, 1, 0, 32'hAABB_CCDD);
    regWr(2'd2, 4'h2, 32'h0);   // byte 0 not enabled: swap stays on
    issue(32'hFD20_0020, 2'd2, 0, 0, 0);
    regWr(2'd2, 4'h1, 32'h0);

    // R2 R3 refusals
    issue(32'hFD20_0000, 2'd2, 1, 1, 32'h5);
    issue(32'hFD20_0000, 2'd3, 0, 0, 0);
    issue(32'hFD20_0001, 2'd1, 0, 0, 0);
    issue(32'hFD20_0002, 2'd2, 1, 0, 32'h7);
    // R1 outside window on both edges
    issue(32'hFD40_0000, 2'd0, 0, 0, 0);
    issue(32'hFD1F_FFFC, 2'd2, 0, 0, 0);

    // R11 R10 mixed traffic with register changes
    for (int i = 0; i < 80; i++) begin
      if (i % 7 == 0) regWr(2'($urandom_range(0, 3)), 4'($urandom), $urandom);
      issue({11'h7E9, 21'($urandom)} ^ (($urandom_range(0, 9) == 0) ? 32'h0100_0000 : 0),
            2'($urandom_range(0, 3)), 1'($urandom), ($urandom_range(0, 7) == 0), $urandom);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule